// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This unit runs the instructions of a zero-address stack machine. It keeps an operand stack of its own, and it takes in one instruction at a time. Each instruction has a 3-bit opcode and an address, and the address is used only by the two memory instructions. A push reads one word from a synchronous data memory and places it on top of the stack. A pop takes the top entry off the stack and writes it to the memory. The arithmetic instructions (add, subtract, multiply) never use the memory. They take two entries off the stack and put one result back.

Every instruction ends with a one-cycle `done` pulse. An underflow or overflow flag may be raised in that same cycle. A push takes one cycle longer than the other instructions, because the memory returns read data one cycle after the request. While `busy` is high the unit ignores its instruction input.

Opcode encoding:

| Code | Instruction |
|------|-------------|
| 1 | push |
| 2 | pop |
| 3 | add |
| 4 | subtract |
| 5 | multiply |
| 0, 6, 7 | no operation |

Top module: `stack_exec_unit`

## Requirements
- R1: A push (opcode 1) drives `mem_rd_en` with `mem_rd_addr` equal to the instruction address in its issue cycle. `busy` is high for the next cycle, and in the cycle after that `done` pulses with the read word now on top of the stack.
- R2: A pop (opcode 2) on a non-empty stack drives `mem_wr_en` in its issue cycle. `mem_wr_addr` equals the instruction address and `mem_wr_data` equals the top entry. The entry is removed, and `done` pulses in the next cycle.
- R3: Add (opcode 3) replaces the two top entries with their sum modulo 2^16.
- R4: Multiply (opcode 5) replaces the two top entries with the low 16 bits of their product.
- R5: Subtract (opcode 4) replaces the two top entries with (top − next) modulo 2^16. So pushing E, then X, then subtracting leaves X − E.
- R6: An arithmetic opcode issued with fewer than two entries on the stack raises `err_underflow` together with `done`. It leaves the stack unchanged and touches no memory port.
- R7: A push while 8 entries are held raises `err_overflow` together with `done` in the next cycle. No memory read is made and the stack is unchanged.
- R8: A pop on an empty stack raises `err_underflow` together with `done` in the next cycle, and no memory write is made.
- R9: While `busy` is high, `instr_valid` is ignored. No memory port is driven, and no extra `done` follows.
- R10: After reset, `busy`, `done`, both error flags and both memory enables are low, and the stack is empty.
- R11: Opcodes 0, 6 and 7 complete with `done` in the next cycle. They raise no error flag, touch no memory port and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr_op | input | 3 | Opcode |
| instr_addr | input | 8 | Memory address for push and pop |
| busy | output | 1 | Push waiting for read data; input ignored |
| done | output | 1 | One-cycle completion pulse |
| err_underflow | output | 1 | Too few entries, valid with done |
| err_overflow | output | 1 | Push onto a full stack, valid with done |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 8 | Memory read address |
| mem_rd_data | input | 16 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 8 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |

## Verification
Two situations are hard to reach from the ports. The first is an instruction presented during the single busy cycle of a push. The bench holds `instr_valid` high with a pop into that cycle. It then checks that no write strobe appears and that only one completion arrives. Later pops confirm the stack depth. The second is a full stack: the bench pushes eight words and then a ninth. It then drains the stack to check that the overflow left the last-in-first-out order intact.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MULT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_PUSH,
        ST_POP,
        ST_FOLD
    } stk_cmd_e;

    typedef enum logic {
        CTL_IDLE,
        CTL_FILL
    } ctl_e;

    function automatic logic is_arith(input logic [2:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_MULT);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_SUB:  res = top - nxt;
            OP_MULT: res = top * nxt;
            default: res = top + nxt;
        endcase
    end

endmodule

// File: rtl/stk_store.sv
module stk_store
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  stk_cmd_e                     cmd,
    input  logic [DATA_W-1:0]            wdata,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic [DATA_W-1:0]            top,
    output logic [DATA_W-1:0]            nxt
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

    logic [DATA_W-1:0] ent [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  below_top;
    logic [CNT_W-1:0]  below_nxt;

    assign cnt       = cnt_q;
    assign below_top = cnt_q - CNT_W'(1);
    assign below_nxt = cnt_q - TWO;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else if ((cmd == ST_PUSH && cnt_q == SLOT) ||
                         (cmd == ST_FOLD && below_nxt == SLOT)) begin
                ent[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                ST_PUSH:         cnt_q <= cnt_q + CNT_W'(1);
                ST_POP, ST_FOLD: cnt_q <= cnt_q - CNT_W'(1);
                default:         cnt_q <= cnt_q;
            endcase
        end
    end

    assign top = (cnt_q != '0) ? ent[PTR_W'(below_top)] : '0;
    assign nxt = (cnt_q >= TWO) ? ent[PTR_W'(below_nxt)] : '0;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == ST_PUSH) |-> (cnt_q != FULL_CNT));
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == ST_POP) |-> (cnt_q != '0));
    assert_fold_two_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == ST_FOLD) |-> (cnt_q >= TWO));
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              busy,
    output logic              done,
    output logic              err_underflow,
    output logic              err_overflow,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

    ctl_e              state_q;
    stk_cmd_e          cmd;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] top;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] alu_res;
    logic [CNT_W-1:0]  cnt;
    logic              accept;
    logic              fin;
    logic              under;
    logic              over;
    logic              start_fill;

    assign busy   = (state_q == CTL_FILL);
    assign accept = instr_valid && !busy;

    stk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .wdata (wdata),
        .cnt   (cnt),
        .top   (top),
        .nxt   (nxt)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (instr_op),
        .top (top),
        .nxt (nxt),
        .res (alu_res)
    );

    always_comb begin
        cmd        = ST_HOLD;
        wdata      = mem_rd_data;
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        under      = 1'b0;
        over       = 1'b0;
        fin        = 1'b0;
        start_fill = 1'b0;
        if (busy) begin
            cmd = ST_PUSH;
            fin = 1'b1;
        end else if (accept) begin
            if (instr_op == OP_PUSH) begin
                if (cnt == FULL_CNT) begin
                    over = 1'b1;
                    fin  = 1'b1;
                end else begin
                    mem_rd_en  = 1'b1;
                    start_fill = 1'b1;
                end
            end else if (instr_op == OP_POP) begin
                fin = 1'b1;
                if (cnt == '0) begin
                    under = 1'b1;
                end else begin
                    mem_wr_en = 1'b1;
                    cmd       = ST_POP;
                end
            end else if (is_arith(instr_op)) begin
                fin = 1'b1;
                if (cnt < TWO) begin
                    under = 1'b1;
                end else begin
                    cmd   = ST_FOLD;
                    wdata = alu_res;
                end
            end else begin
                fin = 1'b1;
            end
        end
    end

    assign mem_rd_addr = instr_addr;
    assign mem_wr_addr = instr_addr;
    assign mem_wr_data = top;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= CTL_IDLE;
            done          <= 1'b0;
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
        end else begin
            state_q       <= start_fill ? CTL_FILL : CTL_IDLE;
            done          <= fin;
            err_underflow <= under;
            err_overflow  <= over;
        end
    end

    assert_read_then_busy_R1: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> busy);
    assert_busy_then_done_R1: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done && !busy));
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!mem_rd_en && !mem_wr_en));
    assert_underflow_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        err_underflow |-> (done && !err_overflow));
    assert_overflow_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        err_overflow |-> done);

endmodule

// File: tb/test_stack_exec_unit.sv
module test_stack_exec_unit;

    typedef struct {
        logic  u;
        logic  o;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_op = 3'd0;
    logic [7:0]  instr_addr = 8'd0;
    logic        busy, done, err_underflow, err_overflow;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rd_addr, mem_wr_addr;
    logic [15:0] mem_rd_data = 16'd0;
    logic [15:0] mem_wr_data;

    logic [15:0] bmem [256];
    logic [15:0] mstk [$];
    exp_t        q [$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    stack_exec_unit i_stack_exec_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_addr(instr_addr), .busy(busy), .done(done),
        .err_underflow(err_underflow), .err_overflow(err_overflow),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr];
        if (mem_wr_en) bmem[mem_wr_addr] <= mem_wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every done must match the oldest expectation
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                chk(0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(err_underflow == e.u, e.req, "err_underflow", int'(err_underflow), int'(e.u));
                chk(err_overflow == e.o, e.req, "err_overflow", int'(err_overflow), int'(e.o));
            end
        end
    end

    // called at a negedge; returns at a negedge with valid low
    task automatic issue(input logic [2:0] op, input logic [7:0] a, input string req);
        exp_t e;
        logic [15:0] t, n, r;
        bit fills;
        while (busy) @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = a;
        #2;
        e.u = 1'b0; e.o = 1'b0; e.req = req;
        fills = 1'b0;
        case (op)
            3'd1: begin
                if (mstk.size() == 8) begin
                    e.o = 1'b1;
                    chk(mem_rd_en == 1'b0, req, "read on full push", int'(mem_rd_en), 0);
                end else begin
                    chk(mem_rd_en && mem_rd_addr == a, req, "push read addr", int'(mem_rd_addr), int'(a));
                    mstk.push_back(bmem[a]);
                    fills = 1'b1;
                end
            end
            3'd2: begin
                if (mstk.size() == 0) begin
                    e.u = 1'b1;
                    chk(mem_wr_en == 1'b0, req, "write on empty pop", int'(mem_wr_en), 0);
                end else begin
                    t = mstk.pop_back();
                    chk(mem_wr_en && mem_wr_addr == a, req, "pop write addr", int'(mem_wr_addr), int'(a));
                    chk(mem_wr_data == t, req, "pop write data", int'(mem_wr_data), int'(t));
                end
            end
            3'd3, 3'd4, 3'd5: begin
                chk(!mem_wr_en && !mem_rd_en, req, "memory touched by arith", int'({mem_rd_en, mem_wr_en}), 0);
                if (mstk.size() < 2) begin
                    e.u = 1'b1;
                end else begin
                    t = mstk.pop_back();
                    n = mstk.pop_back();
                    if (op == 3'd3) r = t + n;
                    else if (op == 3'd4) r = t - n;
                    else r = t * n;
                    mstk.push_back(r);
                end
            end
            default: begin
                chk(!mem_wr_en && !mem_rd_en, req, "memory touched by nop", int'({mem_rd_en, mem_wr_en}), 0);
            end
        endcase
        q.push_back(e);
        @(negedge clk);
        chk(busy == fills, fills ? "R1" : req, "busy after issue", int'(busy), int'(fills));
        if (fills) chk(done == 1'b0, "R1", "done too early on push", int'(done), 0);
        instr_valid = 1'b0;
    endtask

    task automatic drain_check(input logic [7:0] base, input string req);
        while (mstk.size() > 0) issue(3'd2, base, req);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 16'h0123 + 7);
        bmem[1] = 16'hFFFF; bmem[2] = 16'h0002;
        bmem[3] = 16'h1234; bmem[4] = 16'h0100;
        bmem[5] = 16'd5;    bmem[6] = 16'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R10", "busy/done after reset", int'({busy, done}), 0);
        chk(!err_underflow && !err_overflow, "R10", "errors after reset", int'({err_underflow, err_overflow}), 0);
        chk(!mem_rd_en && !mem_wr_en, "R10", "mem enables after reset", int'({mem_rd_en, mem_wr_en}), 0);

        issue(3'd2, 8'h40, "R8");          // empty after reset: underflow
        issue(3'd3, 8'h00, "R6");          // add on empty
        issue(3'd1, 8'h01, "R1");
        issue(3'd4, 8'h00, "R6");          // sub with one entry
        issue(3'd2, 8'h41, "R2");          // must still hold 0xFFFF

        issue(3'd1, 8'h01, "R1");
        issue(3'd1, 8'h02, "R1");
        issue(3'd3, 8'h00, "R3");          // 0xFFFF + 2 = 0x0001
        issue(3'd2, 8'h42, "R3");

        issue(3'd1, 8'h03, "R1");
        issue(3'd1, 8'h04, "R1");
        issue(3'd5, 8'h00, "R4");          // 0x1234 * 0x0100 low = 0x3400
        issue(3'd2, 8'h43, "R4");

        issue(3'd1, 8'h05, "R1");          // E = 5
        issue(3'd1, 8'h06, "R1");          // X = 3
        issue(3'd4, 8'h00, "R5");          // X - E = 0xFFFE
        issue(3'd2, 8'h44, "R5");

        issue(3'd1, 8'h07, "R1");
        issue(3'd0, 8'h50, "R11");
        issue(3'd6, 8'h51, "R11");
        issue(3'd7, 8'h52, "R11");
        issue(3'd2, 8'h45, "R11");         // entry survives the no-ops

        for (int i = 0; i < 8; i++) issue(3'd1, 8'(8'h10 + i), "R1");
        issue(3'd1, 8'h20, "R7");          // ninth push overflows
        drain_check(8'h60, "R7");

        // R9: instruction held during the busy cycle of a push is ignored
        issue(3'd1, 8'h08, "R1");
        bmem[8'h80] = 16'hBEEF;
        while (busy) @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'd1; instr_addr = 8'h09;
        q.push_back('{u: 1'b0, o: 1'b0, req: "R9"});
        mstk.push_back(bmem[8'h09]);
        @(negedge clk);
        chk(busy == 1'b1, "R9", "busy in fill cycle", int'(busy), 1);
        instr_op = 3'd2; instr_addr = 8'h80;
        #2;
        chk(!mem_wr_en && !mem_rd_en, "R9", "memory touched while busy", int'({mem_rd_en, mem_wr_en}), 0);
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(bmem[8'h80] == 16'hBEEF, "R9", "ignored pop wrote memory", int'(bmem[8'h80]), 16'hBEEF);
        drain_check(8'h70, "R9");
        issue(3'd2, 8'h71, "R8");          // confirm empty again

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R9", "missing done pulses", q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule